// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the command pins of a single-data-rate SDRAM device with four banks, a 13-bit row address and a 9-bit column address. When reset is released it brings the device up in a fixed order. It raises the clock enable, waits out the power-up interval, closes every bank, runs a train of auto-refresh commands and then programs the mode register. When that is finished it raises a completion flag.

From then on it keeps the memory contents alive on its own. A reload counter fires at a fixed interval, and each expiry issues one auto-refresh command. The reload value is computed from the retention period, the clock frequency and the row count, less a safety margin. If the timer expires while the sequencer is still inside a post-command wait, the refresh is held and issued as soon as that wait ends.

All outputs are registered, so each command appears on the pins for exactly one clock after the edge that issues it. Every wait length is a parameter, as is every field of the mode word.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, cke is 0, init_done is 0 and the command pins {csN,rasN,casN,weN} show NOP, encoded 4'b0111.
- R2: cke rises on the first clock edge after reset is released and stays high. PRECHARGE ALL is issued exactly PWRUP_CYC+1 edges later, and no command other than NOP is driven while cke is low.
- R3: The first command after power-up is PRECHARGE ALL, encoded 4'b0010, with address bit 10 set, every other address bit clear and the bank bits at 0.
- R4: Between PRECHARGE ALL and the mode load there are exactly INIT_REFS auto-refresh commands (8 by default), each encoded 4'b0001 with the address and bank bits at 0.
- R5: The command after PRECHARGE follows it after exactly T_RP NOP cycles. The command after each auto-refresh follows it after exactly T_RFC NOP cycles.
- R6: LOAD MODE REGISTER is encoded 4'b0000 with the bank bits at 0. Its address carries the mode word BL_CODE + 8*BURST_ILV + 16*CAS_LAT + 512*WR_SINGLE: burst length code in bits [2:0] (0=1, 1=2, 2=4, 3=8 beats), interleave in bit 3, CAS latency in bits [6:4], zero in bits [8:7], and single-location writes in bit 9. The default fields give 0x0222.
- R7: init_done rises exactly T_MRD+1 edges after the LOAD MODE edge. It is 0 before that and never falls until the next reset.
- R8: When T_RFC < REF_RELOAD+1, the first periodic auto-refresh is issued REF_RELOAD+2 edges after init_done rises. Later ones are issued every REF_RELOAD+1 edges.
- R9: A refresh that comes due during a post-refresh wait is held and issued on the edge right after the wait ends. When T_RFC >= REF_RELOAD+1, periodic refreshes are therefore spaced T_RFC+1 edges apart.
- R10: After init_done only NOP and auto-refresh appear on the command pins. Every non-NOP command lasts a single cycle, and the bank bits are always 0.
- R11: REF_RELOAD equals REF_PERIOD_US*CLK_MHZ/NUM_ROWS - REF_MARGIN, using integer division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ROW_W | Multiplexed address bus |
| bank | output | BANK_W | Bank select bits |
| initDone | output | 1 | High once the power-up sequence has completed |

## Verification
The bench builds two small configurations: one where the refresh wait is shorter than the refresh interval, and one where it is longer, so that the held-refresh path decides the spacing. An off-by-one in any wait counter would shift a command edge by one and break an exact spacing check. A design that dropped a due refresh during a wait, or issued it a cycle late, would widen the gap in the second configuration. Mode words are rebuilt arithmetically from the field parameters for both configurations, which catches a misplaced field. A wrong count of initial refreshes would put the mode load at the wrong event index.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {OP_NOP, OP_PRE, OP_REF, OP_MRS} op_e;
  typedef enum logic [1:0] {WT_PWR, WT_RP, WT_RFC, WT_MRD} wait_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    op_e   op;
    logic  loadWait;
    wait_e waitSel;
    logic  ckeOn;
    logic  doneSet;
    logic  refAck;
  } strobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_REF = 4'b0001;
  localparam logic [3:0] PIN_MRS = 4'b0000;

  localparam int AUTO_PRE_BIT = 10;

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int INIT_REFS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    waitDone,
  input  logic    refDue,
  output strobe_t stb
);

  localparam int CNT_W = (INIT_REFS > 1) ? $clog2(INIT_REFS) : 1;

  typedef enum logic [2:0] {
    S_BOOT, S_PWR, S_PRE, S_IREF, S_MRS, S_IDLE, S_AREF
  } state_e;

  state_e stateQ, stateD;
  logic [CNT_W-1:0] refLeftQ, refLeftD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_BOOT;
      refLeftQ <= '0;
    end else begin
      stateQ   <= stateD;
      refLeftQ <= refLeftD;
    end
  end

  always_comb begin
    stb      = '0;
    stb.op   = OP_NOP;
    stateD   = stateQ;
    refLeftD = refLeftQ;
    unique case (stateQ)
      S_BOOT: begin
        stb.ckeOn    = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = WT_PWR;
        stateD       = S_PWR;
      end
      S_PWR: if (waitDone) begin
        stb.op       = OP_PRE;
        stb.loadWait = 1'b1;
        stb.waitSel  = WT_RP;
        stateD       = S_PRE;
      end
      S_PRE: if (waitDone) begin
        stb.op       = OP_REF;
        stb.loadWait = 1'b1;
        stb.waitSel  = WT_RFC;
        refLeftD     = CNT_W'(INIT_REFS - 1);
        stateD       = S_IREF;
      end
      S_IREF: if (waitDone) begin
        stb.loadWait = 1'b1;
        if (refLeftQ != '0) begin
          stb.op      = OP_REF;
          stb.waitSel = WT_RFC;
          refLeftD    = refLeftQ - 1'b1;
        end else begin
          stb.op      = OP_MRS;
          stb.waitSel = WT_MRD;
          stateD      = S_MRS;
        end
      end
      S_MRS: if (waitDone) begin
        stb.doneSet = 1'b1;
        stateD      = S_IDLE;
      end
      S_IDLE: if (refDue) begin
        stb.op       = OP_REF;
        stb.refAck   = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = WT_RFC;
        stateD       = S_AREF;
      end
      S_AREF: if (waitDone) begin
        if (refDue) begin
          stb.op       = OP_REF;
          stb.refAck   = 1'b1;
          stb.loadWait = 1'b1;
          stb.waitSel  = WT_RFC;
        end else begin
          stateD = S_IDLE;
        end
      end
      default: stateD = S_BOOT;
    endcase
  end

endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W      = 13,
  parameter int BANK_W     = 2,
  parameter int PWRUP_CYC  = 20000,
  parameter int T_RP       = 2,
  parameter int T_RFC      = 7,
  parameter int T_MRD      = 2,
  parameter int REF_RELOAD = 761,
  parameter logic [ROW_W-1:0] MODE_WORD = 13'h0222
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic              waitDone,
  output logic              refDue,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] bank,
  output logic              initDone
);

  localparam int WMAX1  = (PWRUP_CYC > T_RP) ? PWRUP_CYC : T_RP;
  localparam int WMAX2  = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int WMAX   = (WMAX1 > WMAX2) ? WMAX1 : WMAX2;
  localparam int WAIT_W = $clog2(WMAX + 1);
  localparam int REF_W  = $clog2(REF_RELOAD + 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitVal;
  logic [REF_W-1:0]  refCnt;
  logic              refRun;
  logic              refPend;
  logic [3:0]        pinCmd;
  logic [ROW_W-1:0]  addrNext;

  // Shared post-command wait counter
  always_comb begin
    unique case (stb.waitSel)
      WT_PWR:  waitVal = WAIT_W'(PWRUP_CYC);
      WT_RP:   waitVal = WAIT_W'(T_RP);
      WT_RFC:  waitVal = WAIT_W'(T_RFC);
      default: waitVal = WAIT_W'(T_MRD);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (stb.loadWait)    waitCnt <= waitVal;
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt == '0);

  // Free-running refresh interval timer, armed when init completes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt  <= '0;
      refRun  <= 1'b0;
      refPend <= 1'b0;
    end else begin
      if (stb.doneSet) begin
        refRun <= 1'b1;
        refCnt <= REF_W'(REF_RELOAD);
      end else if (refRun) begin
        if (refCnt == '0) refCnt <= REF_W'(REF_RELOAD);
        else              refCnt <= refCnt - 1'b1;
      end
      if (refRun && refCnt == '0) refPend <= 1'b1;
      else if (stb.refAck)        refPend <= 1'b0;
    end
  end

  assign refDue = refPend;

  // Command pin encoding
  always_comb begin
    addrNext = '0;
    unique case (stb.op)
      OP_PRE: begin
        pinCmd = PIN_PRE;
        addrNext[AUTO_PRE_BIT] = 1'b1;
      end
      OP_REF: pinCmd = PIN_REF;
      OP_MRS: begin
        pinCmd   = PIN_MRS;
        addrNext = MODE_WORD;
      end
      default: pinCmd = PIN_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke                    <= 1'b0;
      {csN, rasN, casN, weN} <= PIN_NOP;
      addr                   <= '0;
      initDone               <= 1'b0;
    end else begin
      cke                    <= cke | stb.ckeOn;
      {csN, rasN, casN, weN} <= pinCmd;
      addr                   <= addrNext;
      initDone               <= initDone | stb.doneSet;
    end
  end

  assign bank = '0;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W         = 13,
  parameter int BANK_W        = 2,
  parameter int PWRUP_CYC     = 20000,
  parameter int T_RP          = 2,
  parameter int T_RFC         = 7,
  parameter int T_MRD         = 2,
  parameter int INIT_REFS     = 8,
  parameter int REF_PERIOD_US = 64000,
  parameter int CLK_MHZ       = 100,
  parameter int NUM_ROWS      = 8192,
  parameter int REF_MARGIN    = 20,
  parameter int BL_CODE       = 2,
  parameter int BURST_ILV     = 0,
  parameter int CAS_LAT       = 2,
  parameter int WR_SINGLE     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] bank,
  output logic              initDone
);

  localparam int REF_RELOAD = REF_PERIOD_US * CLK_MHZ / NUM_ROWS - REF_MARGIN;
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'((BL_CODE & 7) + 8 * (BURST_ILV & 1) + 16 * (CAS_LAT & 7) + 512 * (WR_SINGLE & 1));

  strobe_t stb;
  logic    waitDone;
  logic    refDue;

  sdram_seq_ctrl #(.INIT_REFS(INIT_REFS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .waitDone (waitDone),
    .refDue   (refDue),
    .stb      (stb)
  );

  sdram_seq_dp #(
    .ROW_W      (ROW_W),
    .BANK_W     (BANK_W),
    .PWRUP_CYC  (PWRUP_CYC),
    .T_RP       (T_RP),
    .T_RFC      (T_RFC),
    .T_MRD      (T_MRD),
    .REF_RELOAD (REF_RELOAD),
    .MODE_WORD  (MODE_WORD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .waitDone (waitDone),
    .refDue   (refDue),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .addr     (addr),
    .bank     (bank),
    .initDone (initDone)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ROW_W-1:0]  addr,
  input logic [BANK_W-1:0] bank,
  input logic              initDone
);

  logic [3:0] cmd;
  assign cmd = {csN, rasN, casN, weN};

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  a_r10_only_refresh_after_done: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (cmd == 4'b0111 || cmd == 4'b0001));

  a_r10_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));

  a_r10_bank_zero: assert property (@(posedge clk) disable iff (!rstN)
    bank == '0);

  a_r2_cke_before_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != 4'b0111) |-> cke);

  a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0010) |-> addr[10]);

  a_r6_mode_word: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0000) |-> (addr == MODE_WORD && !initDone));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .MODE_WORD(MODE_WORD)
) u_chk (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .addr(addr), .bank(bank), .initDone(initDone)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  typedef int evarr_t [64];

  // Configuration A: refresh wait shorter than interval
  localparam int A_PWR = 10, A_RP = 2, A_RFC = 3, A_MRD = 2;
  localparam int A_PER = 64, A_MHZ = 100, A_ROWS = 256, A_MARG = 20;
  localparam int A_BL = 2, A_ILV = 0, A_CL = 2, A_WS = 1;
  // Configuration B: refresh wait longer than interval
  localparam int B_PWR = 6, B_RP = 1, B_RFC = 9, B_MRD = 3;
  localparam int B_PER = 32, B_MHZ = 50, B_ROWS = 64, B_MARG = 20;
  localparam int B_BL = 3, B_ILV = 1, B_CL = 3, B_WS = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic aCke, aCs, aRas, aCas, aWe, aDone;
  logic [12:0] aAddr;
  logic [1:0]  aBank;
  logic bCke, bCs, bRas, bCas, bWe, bDone;
  logic [12:0] bAddr;
  logic [1:0]  bBank;

  sdram_init_seq #(
    .PWRUP_CYC(A_PWR), .T_RP(A_RP), .T_RFC(A_RFC), .T_MRD(A_MRD), .INIT_REFS(8),
    .REF_PERIOD_US(A_PER), .CLK_MHZ(A_MHZ), .NUM_ROWS(A_ROWS), .REF_MARGIN(A_MARG),
    .BL_CODE(A_BL), .BURST_ILV(A_ILV), .CAS_LAT(A_CL), .WR_SINGLE(A_WS)
  ) u_sdram_init_seq (
    .clk(clk), .rstN(rstN), .cke(aCke), .csN(aCs), .rasN(aRas), .casN(aCas),
    .weN(aWe), .addr(aAddr), .bank(aBank), .initDone(aDone)
  );

  sdram_init_seq #(
    .PWRUP_CYC(B_PWR), .T_RP(B_RP), .T_RFC(B_RFC), .T_MRD(B_MRD), .INIT_REFS(8),
    .REF_PERIOD_US(B_PER), .CLK_MHZ(B_MHZ), .NUM_ROWS(B_ROWS), .REF_MARGIN(B_MARG),
    .BL_CODE(B_BL), .BURST_ILV(B_ILV), .CAS_LAT(B_CL), .WR_SINGLE(B_WS)
  ) u_sdram_init_seq_b (
    .clk(clk), .rstN(rstN), .cke(bCke), .csN(bCs), .rasN(bRas), .casN(bCas),
    .weN(bWe), .addr(bAddr), .bank(bBank), .initDone(bDone)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  evarr_t aK, aT, aA, aB, bK, bT, bA, bB;
  int aN = 0, bN = 0;
  int aCkeT = -1, aDoneT = -1, bCkeT = -1, bDoneT = -1;
  bit aFell = 0, bFell = 0, aSeen = 0, bSeen = 0;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  always @(negedge clk) if (rstN) begin
    if (aCke && aCkeT < 0) aCkeT = cyc;
    if (aDone) begin aSeen = 1; if (aDoneT < 0) aDoneT = cyc; end
    else if (aSeen) aFell = 1;
    if ({aCs, aRas, aCas, aWe} != 4'b0111 && aN < 64) begin
      aK[aN] = int'({aCs, aRas, aCas, aWe}); aT[aN] = cyc;
      aA[aN] = int'(aAddr); aB[aN] = int'(aBank); aN++;
    end
    if (bCke && bCkeT < 0) bCkeT = cyc;
    if (bDone) begin bSeen = 1; if (bDoneT < 0) bDoneT = cyc; end
    else if (bSeen) bFell = 1;
    if ({bCs, bRas, bCas, bWe} != 4'b0111 && bN < 64) begin
      bK[bN] = int'({bCs, bRas, bCas, bWe}); bT[bN] = cyc;
      bA[bN] = int'(bAddr); bB[bN] = int'(bBank); bN++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic analyse(input string nm, input int n, input evarr_t k, input evarr_t t,
                         input evarr_t a, input evarr_t b, input int ckeT, input int doneT,
                         input bit fell, input int pwr, input int trp, input int trfc,
                         input int tmrd, input int per, input int mhz, input int rows,
                         input int marg, input int bl, input int ilv, input int cl, input int ws);
    int rel, mode, gap, bankBad, kindBad;
    rel  = per * mhz / rows - marg;                 // R11
    mode = bl + 8 * ilv + 16 * cl + 512 * ws;       // R6
    gap  = (trfc >= rel + 1) ? trfc + 1 : rel + 1;  // R8 / R9
    $display("config %s: reload=%0d mode=0x%0h events=%0d", nm, rel, mode, n);
    check(n >= 14, {"R4 ", nm, " event count"}, n, 14);
    if (n < 14) return;
    check(ckeT == 1, {"R2 ", nm, " cke rise edge"}, ckeT, 1);
    check(t[0] - ckeT == pwr + 1, {"R2 ", nm, " power-up delay"}, t[0] - ckeT, pwr + 1);
    check(k[0] == 2, {"R3 ", nm, " precharge code"}, k[0], 2);
    check(a[0] == 1024, {"R3 ", nm, " precharge address"}, a[0], 1024);
    check(t[1] - t[0] == trp + 1, {"R5 ", nm, " tRP gap"}, t[1] - t[0], trp + 1);
    for (int i = 1; i <= 8; i++) begin
      check(k[i] == 1 && a[i] == 0, {"R4 ", nm, " init refresh code/addr"}, k[i], 1);
      check(t[i + 1] - t[i] == trfc + 1, {"R5 ", nm, " tRFC gap"}, t[i + 1] - t[i], trfc + 1);
    end
    check(k[9] == 0, {"R6 ", nm, " mode load code"}, k[9], 0);
    check(a[9] == mode, {"R6 ", nm, " mode word"}, a[9], mode);
    check(doneT - t[9] == tmrd + 1, {"R7 ", nm, " done after mode load"}, doneT - t[9], tmrd + 1);
    check(!fell, {"R7 ", nm, " done sticky"}, int'(fell), 0);
    check(t[10] - doneT == rel + 2, {"R8 R11 ", nm, " first periodic refresh"}, t[10] - doneT, rel + 2);
    for (int i = 11; i < n; i++)
      check(t[i] - t[i - 1] == gap,
            {(trfc >= rel + 1) ? "R9 " : "R8 ", nm, " periodic spacing"}, t[i] - t[i - 1], gap);
    bankBad = 0; kindBad = 0;
    for (int i = 0; i < n; i++) begin
      if (b[i] != 0) bankBad++;
      if (i >= 10 && (k[i] != 1 || a[i] != 0)) kindBad++;
    end
    check(bankBad == 0, {"R10 ", nm, " bank bits"}, bankBad, 0);
    check(kindBad == 0, {"R10 ", nm, " post-init commands"}, kindBad, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!aCke && !aDone && {aCs, aRas, aCas, aWe} == 4'b0111, "R1 A reset state",
          int'({aCke, aDone, aCs, aRas, aCas, aWe}), 7);
    check(!bCke && !bDone && {bCs, bRas, bCas, bWe} == 4'b0111, "R1 B reset state",
          int'({bCke, bDone, bCs, bRas, bCas, bWe}), 7);
    rstN = 1'b1;
    wait (cyc >= 260);
    @(negedge clk);
    analyse("A", aN, aK, aT, aA, aB, aCkeT, aDoneT, aFell, A_PWR, A_RP, A_RFC, A_MRD,
            A_PER, A_MHZ, A_ROWS, A_MARG, A_BL, A_ILV, A_CL, A_WS);
    analyse("B", bN, bK, bT, bA, bB, bCkeT, bDoneT, bFell, B_PWR, B_RP, B_RFC, B_MRD,
            B_PER, B_MHZ, B_ROWS, B_MARG, B_BL, B_ILV, B_CL, B_WS);
    summary();
  end

  initial begin
    #100000;
    check(1'b0, "watchdog expired", cyc, 260);
    summary();
  end

endmodule